// File: doc/BRIEF.md
# PHY Management Frame Controller

This block runs the two-wire management link to an Ethernet PHY from a small register interface. Software programs a clock divisor and then writes one 32-bit command word to the data register. The controller sends a full management frame on the clock and data pins: a run of 32 ones, then the 32 command bits, most significant first. For a read command it stops driving the data pin at the turnaround field. It then collects the sixteen bits the PHY returns and places them in the low half of the data register.

When the last bit has gone out, a sticky completion flag is set in the event register. Software clears the flag by writing a one to it. While a frame is running, the busy output is high and the controller refuses new commands, so the command in flight cannot be corrupted. A divisor of zero parks the management clock low and no frame can start.

Register map (`reg_addr`): 0 = data/command, 1 = clock divisor (bits 5:0), 2 = event (completion flag at bit 23), 3 = reads zero. Command word fields: start bits 31:30 (`01`), operation 29:28 (`10` read, `01` write), PHY address 27:23, register number 22:18, turnaround 17:16 (`10`), data 15:0.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Each frame is 64 bit periods long: 32 preamble ones, then command bits 31 down to 0. `mdio_o` changes only at MDC falling edges and is stable at every MDC rising edge.
- R2: With divisor S (1..63), MDC has a period of 2*S system clocks, starting low for S clocks. MDC is low whenever the block is idle.
- R3: With divisor 0, a data-register write is stored but starts no frame: `busy` and MDC stay low.
- R4: For a read command (bits 29:28 = `10`), `mdio_oe` is high for bit periods 0..45 only, so it is released from command bit 17 onward. `mdio_in` is sampled at the rising MDC edges of periods 48..63. The sixteen samples, MSB first, replace data[15:0], and data[31:16] keep the command.
- R5: For a write command, `mdio_oe` is high for all 64 bit periods and the data register keeps the command word.
- R6: A read where no device drives the line (input pulled high) returns 0xFFFF in data[15:0].
- R7: `busy` rises on the clock after an accepted data write and falls at the end of the frame. Writes to the data or divisor register while `busy` is high are ignored.
- R8: Frame completion sets event bit 23. Writing a word with bit 23 set clears it, and writing a word with bit 23 clear leaves it set. A completion in the same cycle as a clear leaves the bit set.
- R9: After reset, all registers read zero, and `busy`, `mdc` and `mdio_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| busy | output | 1 | A frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for management data |
| mdio_in | input | 1 | Management data in (line state) |

## Verification
The bench sweeps several divisors and command words and captures every bit at the MDC rising edges. It compares them with the preamble and command image. A wrong bit-index mapping shows up as a shifted or reversed frame. A wrong turnaround boundary shows up as the drive enable lingering into the PHY's reply, or releasing too early for a write. A bench PHY answers reads with known words, and an absent PHY must yield 0xFFFF. An off-by-one in the capture window would lose or duplicate a data bit. The bench also aims a data write into the middle of a frame and a clear at the exact completion cycle. A divisor of zero is tested too, to catch a controller that starts anyway or lets the clock run.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int PRE_BITS   = 32;
    localparam int CMD_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + CMD_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int RDATA_BITS = 16;
    localparam int TA_POS     = 17;
    localparam int REL_IDX    = PRE_BITS + (CMD_BITS - 1 - TA_POS);
    localparam int CAP_IDX    = FRAME_BITS - RDATA_BITS;
    localparam int EVT_BIT    = 23;

    typedef enum logic [1:0] {
        RA_DATA  = 2'd0,
        RA_SPEED = 2'd1,
        RA_EVENT = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [1:0]  st;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [1:0]  ta;
        logic [15:0] data;
    } mgmt_cmd_t;

    function automatic logic cmd_is_read(mgmt_cmd_t c);
        return c.op == 2'b10;
    endfunction

    function automatic logic frame_bit(mgmt_cmd_t c, logic [IDX_W-1:0] idx);
        logic [CMD_BITS-1:0] bits;
        logic [IDX_W-1:0]    pos;
        bits = c;
        pos  = IDX_W'(FRAME_BITS - 1) - idx;
        if (idx < IDX_W'(PRE_BITS)) return 1'b1;
        return bits[pos[$clog2(CMD_BITS)-1:0]];
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SPD_W-1:0] spd,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [SPD_W-1:0] cnt_q;
    logic             mdc_q;
    logic             hit;

    assign hit  = run && (cnt_q == spd - 1'b1);
    assign rise = hit && !mdc_q;
    assign fall = hit && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (hit) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_MDC_STOPS_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc_q) else $error("mdc not parked");  // R2
    AST_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise, fall})) else $error("edge clash");  // R2

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  mgmt_cmd_t             cmd,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  mdio_in,
    output logic                  busy,
    output logic                  done,
    output logic [RDATA_BITS-1:0] rd_data,
    output logic                  mdio_o,
    output logic                  mdio_oe
);
    logic                  busy_q;
    logic [IDX_W-1:0]      idx_q;
    mgmt_cmd_t             cmd_q;
    logic [RDATA_BITS-1:0] shreg_q;
    logic                  last_bit;
    logic                  rd_mode;

    assign rd_mode  = cmd_is_read(cmd_q);
    assign last_bit = idx_q == IDX_W'(FRAME_BITS - 1);
    assign done     = busy_q && fall && last_bit;
    assign busy     = busy_q;
    assign rd_data  = shreg_q;
    assign mdio_o   = busy_q && frame_bit(cmd_q, idx_q);
    assign mdio_oe  = busy_q && (!rd_mode || idx_q < IDX_W'(REL_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            cmd_q   <= '0;
            shreg_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                idx_q   <= '0;
                cmd_q   <= cmd;
                shreg_q <= '0;
            end
        end else begin
            if (rise && rd_mode && idx_q >= IDX_W'(CAP_IDX))
                shreg_q <= {shreg_q[RDATA_BITS-2:0], mdio_in};
            if (fall) begin
                if (last_bit) busy_q <= 1'b0;
                else          idx_q  <= idx_q + 1'b1;
            end
        end
    end

    AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |=> (busy_q && idx_q == '0)) else $error("bad start");  // R1

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int SPD_W = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic [31:0]           data_q;
    logic [SPD_W-1:0]      spd_q;
    logic                  evt_q;
    logic                  eng_busy;
    logic                  eng_done;
    logic [RDATA_BITS-1:0] eng_rd;
    logic                  rise, fall;
    logic                  wr_data, wr_spd, wr_evt, start;
    reg_addr_e             ra;

    assign ra      = reg_addr_e'(reg_addr);
    assign wr_data = reg_wr && ra == RA_DATA  && !eng_busy;
    assign wr_spd  = reg_wr && ra == RA_SPEED && !eng_busy;
    assign wr_evt  = reg_wr && ra == RA_EVENT && reg_wdata[EVT_BIT];
    assign start   = wr_data && spd_q != '0;

    mdio_clk_div #(.SPD_W(SPD_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (eng_busy),
        .spd  (spd_q),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmd     (mgmt_cmd_t'(reg_wdata)),
        .rise    (rise),
        .fall    (fall),
        .mdio_in (mdio_in),
        .busy    (eng_busy),
        .done    (eng_done),
        .rd_data (eng_rd),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            spd_q  <= '0;
            evt_q  <= 1'b0;
        end else begin
            if (wr_data)
                data_q <= reg_wdata;
            else if (eng_done && cmd_is_read(mgmt_cmd_t'(data_q)))
                data_q[RDATA_BITS-1:0] <= eng_rd;
            if (wr_spd)
                spd_q <= reg_wdata[SPD_W-1:0];
            if (eng_done)
                evt_q <= 1'b1;
            else if (wr_evt)
                evt_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (ra)
            RA_DATA:  reg_rdata = data_q;
            RA_SPEED: reg_rdata[SPD_W-1:0] = spd_q;
            RA_EVENT: reg_rdata[EVT_BIT] = evt_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign busy = eng_busy;

    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && !eng_done && reg_wr && ra == RA_DATA) |=> $stable(data_q))
        else $error("write during frame");  // R7
    AST_DONE_SETS_EVT: assert property (@(posedge clk) disable iff (rst)
        $fell(eng_busy) |-> evt_q) else $error("no event");  // R8
    AST_NO_START_SPD0: assert property (@(posedge clk) disable iff (rst)
        (!eng_busy && spd_q == '0) |=> !eng_busy) else $error("start at zero");  // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> (!mdio_oe && !mdc)) else $error("idle not quiet");  // R2

endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, mdc, mdio_o, mdio_oe, mdio_in;

    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;
    logic        phy_present = 1'b0;
    logic [15:0] phy_resp = '0;
    logic        is_rd = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rcnt = 0;
    int t_rise [0:63];
    logic [63:0] cap_bits;
    logic [63:0] cap_oe;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign mdio_in = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    mdio_mgmt_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always @(posedge mdc) begin
        if (rcnt < 64) begin
            t_rise[rcnt]   = cyc;
            cap_bits[rcnt] = mdio_o;
            cap_oe[rcnt]   = mdio_oe;
        end
        rcnt = rcnt + 1;
    end

    always @(negedge mdc) begin
        if (phy_present && is_rd && rcnt == 47) begin
            phy_en = 1'b1; phy_val = 1'b0;
        end else if (phy_present && is_rd && rcnt >= 48 && rcnt <= 63) begin
            phy_en = 1'b1; phy_val = phy_resp[63 - rcnt];
        end else begin
            phy_en = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // runs one frame and checks bits, enable, timing, result and event
    task automatic run_frame(input int spd, input logic [31:0] cmd,
                             input bit present, input logic [15:0] resp,
                             input bit inject);
        logic [31:0] rd;
        logic [63:0] exp_bits;
        bit bits_ok, oe_ok;
        for (int i = 0; i < 64; i++) exp_bits[i] = (i < 32) ? 1'b1 : cmd[63 - i];
        rcnt = 0;
        is_rd = (cmd[29:28] == 2'b10);
        phy_present = present;
        phy_resp = resp;
        reg_write(2'd2, 32'h0080_0000);
        reg_write(2'd0, cmd);
        check(busy == 1'b1, "R7 busy after start", busy, 1);
        if (inject) begin
            repeat (10) @(negedge clk);
            reg_write(2'd0, 32'hDEAD_BEEF);
            reg_write(2'd1, 32'd9);
        end
        wait_idle();
        @(negedge clk);
        check(busy == 1'b0 && rcnt == 64, "R1 frame length", rcnt, 64);
        check(t_rise[1] - t_rise[0] == 2 * spd, "R2 mdc period", t_rise[1] - t_rise[0], 2 * spd);
        bits_ok = 1'b1; oe_ok = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (cap_oe[i] && cap_bits[i] != exp_bits[i]) bits_ok = 1'b0;
            if (is_rd && cap_oe[i] != (i < 46)) oe_ok = 1'b0;
            if (!is_rd && !cap_oe[i]) oe_ok = 1'b0;
        end
        check(bits_ok, "R1 frame bits", cap_bits, exp_bits);
        check(oe_ok, is_rd ? "R4 read drive window" : "R5 write drive window", cap_oe, 0);
        reg_read(2'd0, rd);
        if (is_rd && present)
            check(rd == {cmd[31:16], resp}, "R4 read result", rd, {cmd[31:16], resp});
        else if (is_rd)
            check(rd == {cmd[31:16], 16'hFFFF}, "R6 absent phy", rd, {cmd[31:16], 16'hFFFF});
        else
            check(rd == cmd, "R5 data kept", rd, cmd);
        reg_read(2'd2, rd);
        check(rd == 32'h0080_0000, "R8 event set", rd, 32'h0080_0000);
        if (inject) begin
            reg_read(2'd1, rd);
            check(rd == spd, "R7 speed write ignored", rd, spd);
        end
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), rd);
            check(rd == 0, "R9 reset register", rd, 0);
        end
        check(!busy && !mdc && !mdio_oe, "R9 reset outputs", {busy, mdc, mdio_oe}, 0);

        // divisor zero: stored, no frame
        reg_write(2'd0, 32'h6082_0000);
        repeat (20) begin
            @(negedge clk);
            if (busy || mdc) check(1'b0, "R3 frame at zero divisor", {busy, mdc}, 0);
        end
        reg_read(2'd0, rd);
        check(rd == 32'h6082_0000 && !busy, "R3 stored no start", rd, 32'h6082_0000);

        for (int s = 1; s <= 4; s++) begin
            logic [31:0] wcmd, rcmd;
            wcmd = 32'h5002_0000 | (32'(s * 7 % 32) << 23) | (32'(s * 5 % 32) << 18) | 32'(16'hA5C3 ^ (s * 16'h1111));
            rcmd = 32'h6002_0000 | (32'((s * 11 + 3) % 32) << 23) | (32'(s * 3 % 32) << 18);
            reg_write(2'd1, 32'(s));
            run_frame(s, wcmd, 1'b0, 16'h0, 1'b0);
            run_frame(s, rcmd, 1'b1, 16'h1234 + 16'(s * 16'h2F1D), 1'b0);
            run_frame(s, rcmd, 1'b0, 16'h0, 1'b0);
        end

        // data and divisor writes during a frame are ignored
        reg_write(2'd1, 32'd2);
        run_frame(2, 32'h6092_C000, 1'b1, 16'h8001, 1'b1);

        // event write-one-to-clear behaviour
        reg_write(2'd2, 32'hFF7F_FFFF);
        reg_read(2'd2, rd);
        check(rd == 32'h0080_0000, "R8 zero write keeps", rd, 32'h0080_0000);
        reg_write(2'd2, 32'h0080_0000);
        reg_read(2'd2, rd);
        check(rd == 0, "R8 one write clears", rd, 0);

        // clear issued in the completion cycle: set wins (divisor 1 -> 128 clocks)
        reg_write(2'd1, 32'd1);
        rcnt = 0; is_rd = 1'b0; phy_present = 1'b0;
        reg_write(2'd0, 32'h5002_0001);
        repeat (127) @(negedge clk);
        reg_addr = 2'd2; reg_wdata = 32'h0080_0000; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        check(!busy, "R7 frame ended at predicted cycle", busy, 0);
        reg_read(2'd2, rd);
        check(rd == 32'h0080_0000, "R8 set beats clear", rd, 32'h0080_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule